// File: doc/BRIEF.md
# Blocked Lookahead Adder/Subtractor

This block adds or subtracts two two's-complement operands of 16 bits. It returns the 16-bit result, the carry out of the top bit and a signed overflow flag. The carry chain is a two-level lookahead. Each bit position forms a generate term and a propagate term from its own operand bits. Each 4-bit group turns its terms into a group generate and a group propagate. A second lookahead stage takes the group terms and the operation's initial carry and produces the carry into every group. No carry ever ripples from one group to the next.

To subtract, the block inverts the second operand and forces the initial carry to 1, so that it adds the two's complement. The overflow flag is the XOR of the carry into the most significant bit and the carry out of it. The three results are captured in one output register, so each operation shows up on the outputs one clock after its operands are presented. The group width and the group count are parameters; the defaults give 4 groups of 4 bits.

Top module: `blocked_lookahead_addsub`

## Requirements
- R1: With `op_sub_i`=0, the `res_o` value seen after a rising edge equals (`opa_i` + `opb_i`) mod 2^16, where the operands are the values present at the previous rising edge.
- R2: With `op_sub_i`=1, `res_o` equals (`opa_i` − `opb_i`) mod 2^16, with the same one-cycle timing as R1.
- R3: In add mode, `carry_o` is bit 16 of the unsigned 17-bit sum of the two operands.
- R4: In subtract mode, `carry_o` is 1 exactly when `opa_i` ≥ `opb_i` as unsigned numbers, which is the carry out of `opa_i` + ~`opb_i` + 1.
- R5: In add mode, `ovf_o` is 1 exactly when both operands have the same sign bit (bit 15) and the sign bit of the result differs from it.
- R6: In subtract mode, `ovf_o` is 1 exactly when the operands' sign bits differ and the sign bit of the result differs from the sign bit of `opa_i`.
- R7: 0x7FFF + 0x0001 gives 0x8000 with `ovf_o`=1 and `carry_o`=0. 0x8000 − 0x0001 gives 0x7FFF with `ovf_o`=1 and `carry_o`=1.
- R8: While `rst` is high at a rising edge, `res_o`, `carry_o` and `ovf_o` are all cleared to 0 at that edge.
- R9: A carry that propagates across every group boundary resolves correctly: 0xFFFF + 0x0001 gives 0x0000 with `carry_o`=1 and `ovf_o`=0.
- R10: R1 to R6 also hold for other choices of group width and group count; in a 2-group-by-2-bit configuration they hold for every operand pair in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs are registered on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_sub_i | input | 1 | Operation select: 0 adds, 1 subtracts |
| opa_i | input | 16 | First operand, two's complement |
| opb_i | input | 16 | Second operand, two's complement |
| res_o | output | 16 | Registered sum or difference |
| carry_o | output | 1 | Registered carry out of the most significant bit |
| ovf_o | output | 1 | Registered signed overflow flag |

## Verification
The in-line properties check, on every cycle after reset, that the registered result matches the arithmetic value of the previous cycle's operands. They also check that the carry matches the unsigned comparison or the carry of the 17-bit sum, and that the overflow flag matches the sign-bit rules for each mode. They also cover the cleared state after reset. Only the bench's scenarios show the group-boundary corners: the maximum-positive and minimum-negative wraps and the carry that runs through every group. Only the bench also drives a second, smaller configuration through every operand pair, which shows that the parameterised lookahead generalises.

// File: rtl/cla_pkg.sv
package cla_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;

  typedef struct packed {
    logic carry;
    logic ovf;
  } cla_flags_t;

endpackage

// File: rtl/cla_bit_terms.sv
// Per-bit generate/propagate formation. The second operand is inverted
// for subtraction before the terms are formed.
module cla_bit_terms #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             invert_b,
  output logic [WIDTH-1:0] gen,
  output logic [WIDTH-1:0] prop
);

  logic [WIDTH-1:0] opb_eff;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      assign opb_eff[i] = opb[i] ^ invert_b;
      assign gen[i]     = opa[i] & opb_eff[i];
      assign prop[i]    = opa[i] ^ opb_eff[i];
    end
  endgenerate

endmodule

// File: rtl/cla_lookahead.sv
// Generic one-level lookahead unit. Every carry is a flat sum of products
// of the generate/propagate inputs and the carry-in, so no carry output
// depends on another carry output. Also exports the block generate and
// propagate terms for use by a higher level.
module cla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen,
  input  logic [N-1:0] prop,
  input  logic         cin,
  output logic [N:0]   carry,
  output logic         blk_gen,
  output logic         blk_prop
);

  always_comb begin
    carry    = '0;
    carry[0] = cin;
    for (int j = 0; j < N; j++) begin
      logic term;
      logic all_p;
      all_p = 1'b1;
      for (int m = 0; m <= j; m++) begin
        all_p = all_p & prop[m];
      end
      term = cin & all_p;
      for (int k = 0; k <= j; k++) begin
        logic prod;
        prod = gen[k];
        for (int m = k + 1; m <= j; m++) begin
          prod = prod & prop[m];
        end
        term = term | prod;
      end
      carry[j+1] = term;
    end
  end

  always_comb begin
    blk_gen = 1'b0;
    for (int k = 0; k < N; k++) begin
      logic prod;
      prod = gen[k];
      for (int m = k + 1; m < N; m++) begin
        prod = prod & prop[m];
      end
      blk_gen = blk_gen | prod;
    end
  end

  assign blk_prop = &prop;

endmodule

// File: rtl/cla_group.sv
// One lookahead group: internal carries from the group carry-in, sum bits,
// and the group generate/propagate terms handed to the second level.
module cla_group #(
  parameter int GW = 4
) (
  input  logic [GW-1:0] gen,
  input  logic [GW-1:0] prop,
  input  logic          grp_cin,
  output logic [GW-1:0] sum,
  output logic          grp_gen,
  output logic          grp_prop,
  output logic          msb_cin
);

  logic [GW:0] carry;

  cla_lookahead #(.N(GW)) u_la (
    .gen      (gen),
    .prop     (prop),
    .cin      (grp_cin),
    .carry    (carry),
    .blk_gen  (grp_gen),
    .blk_prop (grp_prop)
  );

  genvar i;
  generate
    for (i = 0; i < GW; i++) begin : g_sum
      assign sum[i] = prop[i] ^ carry[i];
    end
  endgenerate

  assign msb_cin = carry[GW-1];

endmodule

// File: rtl/blocked_lookahead_addsub.sv
module blocked_lookahead_addsub
  import cla_pkg::*;
#(
  parameter int GROUP_W  = 4,
  parameter int N_GROUPS = 4,
  parameter int WIDTH    = GROUP_W * N_GROUPS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_sub_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o,
  output logic             ovf_o
);

  localparam int MSB = WIDTH - 1;

  op_e              op;
  logic             c0;
  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] prop;
  logic [WIDTH-1:0] sum_d;
  logic [N_GROUPS-1:0] grp_gen;
  logic [N_GROUPS-1:0] grp_prop;
  logic [N_GROUPS-1:0] grp_msb_cin;
  logic [N_GROUPS:0]   grp_carry;
  logic                top_gen_unused;
  logic                top_prop_unused;
  cla_flags_t          flags_d;

  assign op = op_e'(op_sub_i);
  assign c0 = (op == OP_SUB);

  cla_bit_terms #(.WIDTH(WIDTH)) u_terms (
    .opa      (opa_i),
    .opb      (opb_i),
    .invert_b (c0),
    .gen      (gen),
    .prop     (prop)
  );

  // Second level: group carries from group terms and the initial carry.
  cla_lookahead #(.N(N_GROUPS)) u_level2 (
    .gen      (grp_gen),
    .prop     (grp_prop),
    .cin      (c0),
    .carry    (grp_carry),
    .blk_gen  (top_gen_unused),
    .blk_prop (top_prop_unused)
  );

  genvar g;
  generate
    for (g = 0; g < N_GROUPS; g++) begin : g_grp
      cla_group #(.GW(GROUP_W)) u_grp (
        .gen      (gen[g*GROUP_W +: GROUP_W]),
        .prop     (prop[g*GROUP_W +: GROUP_W]),
        .grp_cin  (grp_carry[g]),
        .sum      (sum_d[g*GROUP_W +: GROUP_W]),
        .grp_gen  (grp_gen[g]),
        .grp_prop (grp_prop[g]),
        .msb_cin  (grp_msb_cin[g])
      );
    end
  endgenerate

  assign flags_d.carry = grp_carry[N_GROUPS];
  assign flags_d.ovf   = grp_carry[N_GROUPS] ^ grp_msb_cin[N_GROUPS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      carry_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      res_o   <= sum_d;
      carry_o <= flags_d.carry;
      ovf_o   <= flags_d.ovf;
    end
  end

  // R1 R2
  sum_value_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> res_o == WIDTH'($past(op_sub_i) ? ($past(opa_i) - $past(opb_i))
                                                    : ($past(opa_i) + $past(opb_i))));

  // R3
  add_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(op_sub_i)) |->
      carry_o == (({1'b0, $past(opa_i)} + {1'b0, $past(opb_i)}) >> WIDTH));

  // R4
  sub_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sub_i)) |-> carry_o == ($past(opa_i) >= $past(opb_i)));

  // R5
  add_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(op_sub_i)) |->
      ovf_o == (($past(opa_i[MSB]) == $past(opb_i[MSB])) && (res_o[MSB] != $past(opa_i[MSB]))));

  // R6
  sub_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sub_i)) |->
      ovf_o == (($past(opa_i[MSB]) != $past(opb_i[MSB])) && (res_o[MSB] != $past(opa_i[MSB]))));

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (res_o == '0 && !carry_o && !ovf_o));

endmodule

// File: tb/blocked_lookahead_addsub_bench.sv
module blocked_lookahead_addsub_bench;

  localparam int W  = 16;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          sub_m = 1'b0;
  logic [W-1:0]  a_m = '0, b_m = '0;
  logic [W-1:0]  res_m;
  logic          cy_m, ov_m;

  logic          sub_s = 1'b0;
  logic [SW-1:0] a_s = '0, b_s = '0;
  logic [SW-1:0] res_s;
  logic          cy_s, ov_s;

  int n_tests = 0;
  int n_fail  = 0;

  blocked_lookahead_addsub u_blocked_lookahead_addsub (
    .clk(clk), .rst(rst), .op_sub_i(sub_m), .opa_i(a_m), .opb_i(b_m),
    .res_o(res_m), .carry_o(cy_m), .ovf_o(ov_m)
  );

  blocked_lookahead_addsub #(.GROUP_W(2), .N_GROUPS(2)) u_small (
    .clk(clk), .rst(rst), .op_sub_i(sub_s), .opa_i(a_s), .opb_i(b_s),
    .res_o(res_s), .carry_o(cy_s), .ovf_o(ov_s)
  );

  // Reference computed from integer arithmetic for width w.
  function automatic void ref_calc(input int w, input longint a, input longint b,
                                   input bit sub, output longint r, output bit cy,
                                   output bit ov);
    longint m, sa, sb, sr;
    m  = longint'(1) << w;
    sa = (a >= m/2) ? a - m : a;
    sb = (b >= m/2) ? b - m : b;
    sr = sub ? sa - sb : sa + sb;
    ov = (sr >= m/2) || (sr < -(m/2));
    r  = ((sub ? a - b : a + b) % m + m) % m;
    cy = sub ? (a >= b) : ((a + b) >= m);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_main(input logic [W-1:0] a, input logic [W-1:0] b, input bit sub,
                          input string tag);
    longint r; bit cy, ov;
    @(negedge clk);
    a_m = a; b_m = b; sub_m = sub;
    @(negedge clk);
    ref_calc(W, longint'(a), longint'(b), sub, r, cy, ov);
    check({tag, sub ? " R2 result" : " R1 result"}, longint'(res_m), r);
    check({tag, sub ? " R4 carry" : " R3 carry"}, longint'(cy_m), longint'(cy));
    check({tag, sub ? " R6 ovf" : " R5 ovf"}, longint'(ov_m), longint'(ov));
  endtask

  initial begin
    #2_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R8: reset clears outputs even with live operands
    a_m = 16'h7FFF; b_m = 16'hFFFF; sub_m = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 res", longint'(res_m), 0);
    check("R8 carry", longint'(cy_m), 0);
    check("R8 ovf", longint'(ov_m), 0);
    rst = 1'b0;

    // R7 corners
    run_main(16'h7FFF, 16'h0001, 1'b0, "R7");
    check("R7 add corner", longint'({res_m, cy_m, ov_m}), longint'({16'h8000, 1'b0, 1'b1}));
    run_main(16'h8000, 16'h0001, 1'b1, "R7");
    check("R7 sub corner", longint'({res_m, cy_m, ov_m}), longint'({16'h7FFF, 1'b1, 1'b1}));

    // R9 full propagate through every group
    run_main(16'hFFFF, 16'h0001, 1'b0, "R9");
    check("R9 chain", longint'({res_m, cy_m, ov_m}), longint'({16'h0000, 1'b1, 1'b0}));
    run_main(16'h0000, 16'h0000, 1'b1, "R2 zero");
    run_main(16'h1234, 16'h1234, 1'b1, "R4 equal");
    run_main(16'h8000, 16'h8000, 1'b0, "R5 minneg");

    // Sweep low byte against group-boundary patterns
    for (int i = 0; i < 256; i++) begin
      run_main(16'(i * 257), 16'h0F0F, 1'b0, "sweep");
      run_main(16'(i * 257), 16'hF0F1, 1'b1, "sweep");
    end

    // Random vectors in both modes
    for (int i = 0; i < 1500; i++) begin
      run_main(16'($urandom), 16'($urandom), 1'($urandom), "rand");
    end

    // R10 exhaustive small configuration
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          longint r; bit cy, ov;
          @(negedge clk);
          a_s = SW'(a); b_s = SW'(b); sub_s = 1'(s);
          @(negedge clk);
          ref_calc(SW, longint'(a), longint'(b), 1'(s), r, cy, ov);
          check("R10 small result", longint'(res_s), r);
          check("R10 small carry", longint'(cy_s), longint'(cy));
          check("R10 small ovf", longint'(ov_s), longint'(ov));
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule